// File: doc/BRIEF.md
# Early-Terminating Linear SAD Array

A one-dimensional array of processing elements for full-search block matching. Each element holds the sum of absolute differences (SAD) for one candidate search position. One current-block pixel is broadcast per accepted cycle, and each element takes its own reference pixel on a separate lane. The block is swept in raster order, one row after another, so every candidate's SAD builds up row by row. A full sweep of the block evaluates one group of candidates, called a pass. A macroblock is searched as a series of passes.

At fixed row checkpoints, every element compares its partial SAD with the best SAD found in earlier passes of the same macroblock. An element that is already worse stops accumulating for the rest of the pass, which saves switching activity. At the end of a pass the block reports each element's SAD with a valid flag. It then folds the surviving results into a running best SAD and the index of the winning candidate.

Top module: `sad_early_array`

## Requirements
- R1: After reset, `bestSad` is all ones, `bestIdx` is 0 and `passDone` is low.
- R2: For every element, `sadOut` lane k equals the sum over all BLK_W*BLK_H accepted pixels of |curPix - refPix lane k|, taken as unsigned 8-bit magnitudes in either sign. `sadOk` bit k is 1 when the element was never disabled during the pass.
- R3: A checkpoint falls after each completed group of CHK_ROWS rows (rows 4, 8 and 12 by default), excluding the final row. At a checkpoint, an element whose partial SAD, including the row just finished, is strictly greater than the `bestSad` held at the start of the pass is disabled. A partial SAD equal to that best does not disable the element.
- R4: A disabled element stops accumulating until the next pass starts. Its `sadOut` lane then holds the partial SAD at the moment it was disabled, and its `sadOk` bit is 0.
- R5: Only valid results take part in the best update. The smallest valid SAD that is strictly less than the running best replaces it. On equal SADs, the lower element index wins, and an earlier pass's best is kept. `bestIdx` is {pass number, element index}, with the element index in the low bits.
- R6: `mbStart` resets the running best to all ones and the pass number to 0, and it aborts any partial pass. A pixel presented in the same cycle as `mbStart` is ignored.
- R7: `passDone` is high for exactly one cycle, the cycle after the last pixel of a pass is accepted. `sadOut` and `sadOk` are final in that cycle, and `bestSad` and `bestIdx` show the update one cycle later.
- R8: Pixels are counted only in cycles where `pixValid` is high. Idle cycles inside a pass do not change any result.
- R9: No check follows the last row. An element whose SAD rises above the best only in the final group of rows still ends with `sadOk` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mbStart | input | 1 | Start of a new macroblock; clears the best and the pass number |
| pixValid | input | 1 | A pixel is presented on curPix and refPix |
| curPix | input | 8 | Broadcast current-block pixel |
| refPix | input | 128 | Reference pixel per element, lane k in bits [8k+7:8k] |
| passDone | output | 1 | One-cycle pulse when a pass ends |
| sadOut | output | 256 | SAD per element, lane k in bits [16k+15:16k] |
| sadOk | output | 16 | Per element: 1 = never disabled in this pass |
| bestSad | output | 16 | Running best SAD of the macroblock |
| bestIdx | output | 8 | {pass number, element index} of the best |

## Verification
The bench aims partial SADs exactly at the stored best at a checkpoint. A design that used greater-or-equal would wrongly drop that candidate. It disables elements at each of the three checkpoints, and places a large cost only in the last rows: a design that checked after the final row would flag that candidate invalid, and one that kept adding after a disable would report a SAD larger than the frozen partial. Equal SADs across elements and across passes expose a design that breaks ties the wrong way. Idle gaps inside a pass and a pixel presented together with `mbStart` catch pixel counters that advance when they should not.

// File: rtl/sad_pkg.sv
package sad_pkg;
  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accEn;     // a pixel is accepted this cycle
    logic accLoad;   // first pixel of a pass: restart accumulators
    logic chkNow;    // last pixel of a checkpoint row
    logic passDone;  // accumulators hold final values
    logic mbClear;   // new macroblock
  } ctlStrb_t;
endpackage

// File: rtl/sad_ctrl.sv
module sad_ctrl
  import sad_pkg::*;
#(
  parameter int BLK_W    = 16,
  parameter int BLK_H    = 16,
  parameter int CHK_ROWS = 4,
  parameter int PASS_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mbStart,
  input  logic              pixValid,
  output ctlStrb_t          strb,
  output logic [PASS_W-1:0] passIdx
);
  localparam int COL_W = $clog2(BLK_W);
  localparam int ROW_W = $clog2(BLK_H);
  localparam int CHK_W = $clog2(CHK_ROWS + 1);

  logic [COL_W-1:0] colQ;
  logic [ROW_W-1:0] rowQ;
  logic [CHK_W-1:0] grpQ;
  logic             passDoneQ;
  logic             accEn, colLast, rowLast, grpLast, lastPix;

  assign accEn   = pixValid && !mbStart;
  assign colLast = (colQ == COL_W'(BLK_W - 1));
  assign rowLast = (rowQ == ROW_W'(BLK_H - 1));
  assign grpLast = (grpQ == CHK_W'(CHK_ROWS - 1));
  assign lastPix = accEn && colLast && rowLast;

  always_comb begin
    strb.accEn    = accEn;
    strb.accLoad  = accEn && (colQ == '0) && (rowQ == '0);
    strb.chkNow   = accEn && colLast && grpLast && !rowLast;
    strb.passDone = passDoneQ;
    strb.mbClear  = mbStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colQ <= '0;
      rowQ <= '0;
      grpQ <= '0;
    end else if (mbStart) begin
      colQ <= '0;
      rowQ <= '0;
      grpQ <= '0;
    end else if (accEn) begin
      if (colLast) begin
        colQ <= '0;
        if (rowLast) begin
          rowQ <= '0;
          grpQ <= '0;
        end else begin
          rowQ <= rowQ + 1'b1;
          grpQ <= grpLast ? '0 : grpQ + 1'b1;
        end
      end else begin
        colQ <= colQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passDoneQ <= 1'b0;
      passIdx   <= '0;
    end else begin
      passDoneQ <= lastPix;
      if (mbStart)        passIdx <= '0;
      else if (passDoneQ) passIdx <= passIdx + 1'b1;
    end
  end

  // R7: end-of-pass strobe never lasts two cycles
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    passDoneQ |=> !passDoneQ);

  // R8: an idle cycle leaves the sweep position untouched
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!pixValid && !mbStart) |=> ($stable(colQ) && $stable(rowQ)));

  // R6: a new macroblock restarts the sweep at the first pixel
  p_mb_restart_r6: assert property (@(posedge clk) disable iff (!rstN)
    mbStart |=> (colQ == '0 && rowQ == '0 && passIdx == '0));
endmodule

// File: rtl/sad_pe.sv
module sad_pe #(
  parameter int PIX_W = 8,
  parameter int SAD_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PIX_W-1:0] curPix,
  input  logic [PIX_W-1:0] refPix,
  input  logic             accEn,
  input  logic             accLoad,
  input  logic             chkNow,
  input  logic [SAD_W-1:0] bestRef,
  output logic [SAD_W-1:0] acc,
  output logic             peOn
);
  logic [PIX_W-1:0] absDiff;
  logic [SAD_W-1:0] sumNext;

  assign absDiff = (curPix > refPix) ? (curPix - refPix) : (refPix - curPix);
  assign sumNext = (accLoad ? '0 : acc) + SAD_W'(absDiff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc  <= '0;
      peOn <= 1'b1;
    end else if (accLoad) begin
      acc  <= sumNext;
      peOn <= 1'b1;
    end else if (accEn && peOn) begin
      acc <= sumNext;
      if (chkNow && (sumNext > bestRef)) peOn <= 1'b0;
    end
  end

  // R4: a disabled element keeps its accumulator frozen
  p_frozen_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!peOn && !accLoad) |=> $stable(acc));

  // R3: an element only turns off when its partial exceeds the best
  p_kill_justified_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(peOn) |-> (acc > bestRef));
endmodule

// File: rtl/sad_datapath.sv
module sad_datapath
  import sad_pkg::*;
#(
  parameter int NUM_PE = 16,
  parameter int PIX_W  = 8,
  parameter int SAD_W  = 16,
  parameter int PASS_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrb_t                strb,
  input  logic [PASS_W-1:0]       passIdx,
  input  logic [PIX_W-1:0]        curPix,
  input  logic [NUM_PE*PIX_W-1:0] refPix,
  output logic [NUM_PE*SAD_W-1:0] sadOut,
  output logic [NUM_PE-1:0]       sadOk,
  output logic [SAD_W-1:0]        bestSad,
  output logic [PASS_W+$clog2(NUM_PE)-1:0] bestIdx
);
  localparam int PE_W  = $clog2(NUM_PE);
  localparam int IDX_W = PASS_W + PE_W;

  logic [SAD_W-1:0] accArr [NUM_PE];
  logic [NUM_PE-1:0] onVec;

  for (genvar k = 0; k < NUM_PE; k++) begin : g_pe
    sad_pe #(.PIX_W(PIX_W), .SAD_W(SAD_W)) u_pe (
      .clk     (clk),
      .rstN    (rstN),
      .curPix  (curPix),
      .refPix  (refPix[k*PIX_W +: PIX_W]),
      .accEn   (strb.accEn),
      .accLoad (strb.accLoad),
      .chkNow  (strb.chkNow),
      .bestRef (bestSad),
      .acc     (accArr[k]),
      .peOn    (onVec[k])
    );
    assign sadOut[k*SAD_W +: SAD_W] = accArr[k];
  end

  assign sadOk = onVec;

  // pick smallest valid result, strict compare keeps lower index and old best
  logic [SAD_W-1:0] winVal;
  logic [PE_W-1:0]  winPe;
  logic             winFound;

  always_comb begin
    winVal   = bestSad;
    winPe    = '0;
    winFound = 1'b0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (onVec[i] && (accArr[i] < winVal)) begin
        winVal   = accArr[i];
        winPe    = PE_W'(i);
        winFound = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestSad <= '1;
      bestIdx <= '0;
    end else if (strb.mbClear) begin
      bestSad <= '1;
      bestIdx <= '0;
    end else if (strb.passDone && winFound) begin
      bestSad <= winVal;
      bestIdx <= IDX_W'({passIdx, winPe});
    end
  end

  // R5: within a macroblock the best never gets worse
  p_best_monotone_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.mbClear |=> (bestSad <= $past(bestSad)));

  // R6: a new macroblock restores the maximum best
  p_best_cleared_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.mbClear |=> (bestSad == '1));

  // R5: the best only moves at the end of a pass
  p_best_at_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.passDone && !strb.mbClear) |=> ($stable(bestSad) && $stable(bestIdx)));
endmodule

// File: rtl/sad_early_array.sv
module sad_early_array
  import sad_pkg::*;
#(
  parameter int NUM_PE   = 16,
  parameter int BLK_W    = 16,
  parameter int BLK_H    = 16,
  parameter int CHK_ROWS = 4,
  parameter int PASS_W   = 4,
  parameter int PIX_W    = 8,
  localparam int SAD_W   = $clog2(BLK_W * BLK_H * ((1 << PIX_W) - 1) + 1),
  localparam int IDX_W   = PASS_W + $clog2(NUM_PE)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    mbStart,
  input  logic                    pixValid,
  input  logic [PIX_W-1:0]        curPix,
  input  logic [NUM_PE*PIX_W-1:0] refPix,
  output logic                    passDone,
  output logic [NUM_PE*SAD_W-1:0] sadOut,
  output logic [NUM_PE-1:0]       sadOk,
  output logic [SAD_W-1:0]        bestSad,
  output logic [IDX_W-1:0]        bestIdx
);
  ctlStrb_t          strb;
  logic [PASS_W-1:0] passIdx;

  sad_ctrl #(
    .BLK_W(BLK_W), .BLK_H(BLK_H), .CHK_ROWS(CHK_ROWS), .PASS_W(PASS_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mbStart  (mbStart),
    .pixValid (pixValid),
    .strb     (strb),
    .passIdx  (passIdx)
  );

  sad_datapath #(
    .NUM_PE(NUM_PE), .PIX_W(PIX_W), .SAD_W(SAD_W), .PASS_W(PASS_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .passIdx (passIdx),
    .curPix  (curPix),
    .refPix  (refPix),
    .sadOut  (sadOut),
    .sadOk   (sadOk),
    .bestSad (bestSad),
    .bestIdx (bestIdx)
  );

  assign passDone = strb.passDone;
endmodule

// File: tb/sad_early_array_test.sv
`timescale 1ns/1ps
module sad_early_array_test;
  localparam int NPE = 16;
  localparam int BW  = 16;
  localparam int BH  = 16;
  localparam int CHK = 4;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           mbStart = 1'b0;
  logic           pixValid = 1'b0;
  logic [7:0]     curPix = '0;
  logic [NPE*8-1:0]  refPix = '0;
  logic           passDone;
  logic [NPE*16-1:0] sadOut;
  logic [NPE-1:0] sadOk;
  logic [15:0]    bestSad;
  logic [7:0]     bestIdx;

  sad_early_array uut (
    .clk(clk), .rstN(rstN), .mbStart(mbStart), .pixValid(pixValid),
    .curPix(curPix), .refPix(refPix), .passDone(passDone), .sadOut(sadOut),
    .sadOk(sadOk), .bestSad(bestSad), .bestIdx(bestIdx)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int rowDiff [NPE][BH];
  int expSad [NPE];
  bit expOk [NPE];
  int bestModel = 65535;
  int bestIdxModel = 0;
  int passModel = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setAll(input int d);
    for (int p = 0; p < NPE; p++)
      for (int r = 0; r < BH; r++) rowDiff[p][r] = d;
  endtask

  task automatic setRows(input int p, input int r0, input int r1, input int d);
    for (int r = r0; r <= r1; r++) rowDiff[p][r] = d;
  endtask

  // expected per-element results from the requirements
  task automatic model();
    for (int p = 0; p < NPE; p++) begin
      int part = 0;
      bit off = 0;
      for (int r = 0; r < BH; r++) begin
        if (!off) part += rowDiff[p][r] * BW;
        if (!off && ((r + 1) % CHK == 0) && r != BH - 1 && part > bestModel) off = 1;
      end
      expSad[p] = part;
      expOk[p]  = !off;
    end
  endtask

  task automatic runPass(input bit gaps);
    model();
    for (int r = 0; r < BH; r++) begin
      for (int c = 0; c < BW; c++) begin
        @(negedge clk);
        if (gaps && c == 3) begin
          pixValid = 1'b0;
          curPix = 8'hAA;
          @(negedge clk);
        end
        pixValid = 1'b1;
        curPix = (c % 2 == 0) ? 8'd20 : 8'd235;
        for (int p = 0; p < NPE; p++)
          refPix[p*8 +: 8] = (c % 2 == 0) ? 8'(20 + rowDiff[p][r]) : 8'(235 - rowDiff[p][r]);
      end
    end
    @(negedge clk);
    pixValid = 1'b0;
    chk(passDone == 1'b1, "R7 passDone after last pixel", int'(passDone), 1);
    for (int p = 0; p < NPE; p++) begin
      chk(int'(sadOut[p*16 +: 16]) == expSad[p], $sformatf("R2/R4 sad pe%0d", p),
          int'(sadOut[p*16 +: 16]), expSad[p]);
      chk(sadOk[p] == expOk[p], $sformatf("R3/R9 ok pe%0d", p), int'(sadOk[p]), int'(expOk[p]));
    end
    for (int p = 0; p < NPE; p++)
      if (expOk[p] && expSad[p] < bestModel) begin
        bestModel = expSad[p];
        bestIdxModel = passModel * NPE + p;
      end
    passModel++;
    @(negedge clk);
    chk(passDone == 1'b0, "R7 passDone one cycle", int'(passDone), 0);
    chk(int'(bestSad) == bestModel, "R5 bestSad", int'(bestSad), bestModel);
    chk(int'(bestIdx) == bestIdxModel, "R5 bestIdx", int'(bestIdx), bestIdxModel);
  endtask

  task automatic testReset();
    chk(bestSad == 16'hFFFF, "R1 bestSad reset", int'(bestSad), 65535);
    chk(bestIdx == 8'd0, "R1 bestIdx reset", int'(bestIdx), 0);
    chk(passDone == 1'b0, "R1 passDone reset", int'(passDone), 0);
  endtask

  // R2: plain sums, nothing disabled on the first pass
  task automatic testFirstPass();
    for (int p = 0; p < NPE; p++) setRows(p, 0, BH - 1, p + 1);
    runPass(1'b0);
  endtask

  // R3 R4 R5 R8 R9: checkpoints, equality, ties, late cost, idle gaps
  task automatic testCheckpoints();
    setAll(3);
    setAll(3);
    setRows(0, 0, 15, 20);
    setRows(1, 0, 15, 0); setRows(1, 0, 3, 4);
    setRows(2, 0, 15, 0); setRows(2, 4, 7, 5);
    setRows(3, 0, 15, 0); setRows(3, 12, 15, 10);
    setRows(4, 0, 15, 0); setRows(4, 0, 11, 1);
    setRows(5, 0, 15, 0); setRows(5, 8, 15, 10);
    setRows(9, 0, 15, 0); setRows(9, 0, 1, 4);
    setRows(11, 0, 15, 0); setRows(11, 14, 15, 4);
    runPass(1'b1);
  endtask

  // R6: new macroblock with a pixel in the same cycle
  task automatic testNewMb();
    @(negedge clk);
    mbStart = 1'b1;
    pixValid = 1'b1;
    curPix = 8'd0;
    refPix = '1;
    @(negedge clk);
    mbStart = 1'b0;
    pixValid = 1'b0;
    chk(bestSad == 16'hFFFF, "R6 best cleared", int'(bestSad), 65535);
    chk(bestIdx == 8'd0, "R6 index cleared", int'(bestIdx), 0);
    bestModel = 65535;
    bestIdxModel = 0;
    passModel = 0;
    setAll(200);
    setRows(7, 0, 15, 150);
    setRows(12, 0, 15, 150);
    runPass(1'b0);
  endtask

  // R3 R5: kill at the last checkpoint, later pass improves best
  task automatic testSecondPass();
    setAll(100);
    setRows(14, 0, 15, 210);
    runPass(1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstPass();
    testCheckpoints();
    testNewMb();
    testSecondPass();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule